// File: doc/BRIEF.md
# Charger protection fault sequencer

This block is the digital decision-maker behind a charger input protection switch. It decides, cycle by cycle, whether the pass switch is on. Its inputs are already-synchronised comparator flags: supply above the power-on level, input over-voltage, over-current, battery over-voltage and over-temperature. It also takes an active-high disable and a timebase tick of one microsecond. All blanking, recovery and start-up intervals are counted in ticks, so each interval has a fixed length in time, whatever the clock rate.

On power-up the switch is held off for a start-up interval. After that it is on unless a protection condition or the disable input removes it. Input over-voltage and over-temperature act at once. Over-current and battery over-voltage must persist for a blanking interval before they act. Every over-current or battery shutdown increments one shared event counter. When the counter reaches its limit, the switch is latched off. The latch is released only by a supply drop or by a pulse on the disable input. An active-low fault output reports the protection conditions to a host. A latched-off status output is also provided.

Top module: `chg_guard_seq`

## Requirements
- R1: After `pwr_ok` rises, `sw_en` stays low for POR_TICKS ticks and goes high on the clock edge that counts the last of them, provided no other condition is active.
- R2: While `pwr_ok` is low, `sw_en` and `latched` are low and `fault_n` is high. A supply drop clears the event counter and the latch, and it restarts the start-up interval.
- R3: `in_ovp` high forces `sw_en` low in the same cycle, with no blanking, and drives `fault_n` low.
- R4: After `in_ovp` falls, `sw_en` stays low and `fault_n` stays low for OVP_REC_TICKS ticks. Both then return high.
- R5: `oc_flag` turns the switch off only after OC_BLANK_TICKS consecutive ticks. A shorter pulse has no effect and restarts the blanking count.
- R6: After an over-current shutdown, the switch stays off for OC_REC_TICKS ticks. It then turns back on and monitoring restarts, with a fresh blanking count.
- R7: `bat_ovp` turns the switch off after BAT_BLANK_TICKS consecutive ticks. The switch turns back on at the first clock edge after `bat_ovp` falls.
- R8: Over-current and battery shutdowns share one saturating counter. The FAULT_LIMIT-th shutdown sets `latched`. After that, `sw_en` stays low and `fault_n` stays low, whatever the fault flags do, while the one before the limit does not latch.
- R9: `disable_in` high forces `sw_en` low at once. While it is high, the counter and the latch are cleared, so on re-enable the switch comes back on.
- R10: `fault_n` is low during input over-voltage and its recovery, during an over-current or battery shutdown, and while latched. It stays high for over-temperature alone.
- R11: `hot` forces `sw_en` low in the same cycle. When `hot` clears, `sw_en` returns in the same cycle, with no delay and no count.
- R12: Timers advance only on cycles where `tick` is high. With `tick` held low, no interval progresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle wide, once per microsecond |
| pwr_ok | input | 1 | Supply above the power-on threshold |
| in_ovp | input | 1 | Input over-voltage flag |
| oc_flag | input | 1 | Output over-current flag |
| bat_ovp | input | 1 | Battery over-voltage flag |
| hot | input | 1 | Over-temperature flag |
| disable_in | input | 1 | Active-high disable; tie low when unused |
| sw_en | output | 1 | Pass-switch enable |
| fault_n | output | 1 | Active-low fault indication |
| latched | output | 1 | Switch latched off by the event limit |

## Verification
The properties assume that every flag input is already synchronous to `clk` and changes only between edges. They also assume that `pwr_ok` low is the only supply indication, so no fault flag needs meaning while the supply is absent. The bench drives all inputs on the falling clock edge, so this assumption holds throughout. It holds `tick` high on every cycle, except in the interval where tick gating itself is under test. The bench also overrides the interval parameters with short values, so that every recovery and latch path fits in a few hundred cycles.

// File: rtl/chg_guard_seq.sv
module chg_guard_seq #(
  parameter int POR_TICKS       = 8000,
  parameter int OVP_REC_TICKS   = 8000,
  parameter int OC_BLANK_TICKS  = 176,
  parameter int OC_REC_TICKS    = 64000,
  parameter int BAT_BLANK_TICKS = 176,
  parameter int FAULT_LIMIT     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_ok,
  input  logic in_ovp,
  input  logic oc_flag,
  input  logic bat_ovp,
  input  logic hot,
  input  logic disable_in,
  output logic sw_en,
  output logic fault_n,
  output logic latched
);
  localparam int T1   = (POR_TICKS > OVP_REC_TICKS) ? POR_TICKS : OVP_REC_TICKS;
  localparam int TMAX = (T1 > OC_REC_TICKS) ? T1 : OC_REC_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BMAX = (OC_BLANK_TICKS > BAT_BLANK_TICKS) ? OC_BLANK_TICKS : BAT_BLANK_TICKS;
  localparam int BW   = $clog2(BMAX + 1);
  localparam int CW   = $clog2(FAULT_LIMIT + 1);
  localparam int CW1  = CW + 1;

  logic          run;
  logic [TW-1:0] por_tmr, ovp_tmr, oc_tmr;
  logic          ovp_rec;
  logic [BW-1:0] oc_blk, bat_blk;
  logic          oc_trip, bat_trip;
  logic [CW-1:0] fcnt;
  logic          at_limit, monitor, oc_fire, bat_fire;
  logic [CW:0]   fsum;

  assign at_limit = (fcnt == CW'(FAULT_LIMIT));
  assign monitor  = run & ~disable_in & ~at_limit;
  assign oc_fire  = monitor & ~oc_trip & oc_flag & tick &
                    (oc_blk == BW'(OC_BLANK_TICKS - 1));
  assign bat_fire = monitor & ~bat_trip & bat_ovp & tick &
                    (bat_blk == BW'(BAT_BLANK_TICKS - 1));
  assign fsum     = {1'b0, fcnt} + CW1'(oc_fire) + CW1'(bat_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      por_tmr <= '0;
    end else if (!pwr_ok) begin
      run     <= 1'b0;
      por_tmr <= '0;
    end else if (!run && tick) begin
      if (por_tmr == TW'(POR_TICKS - 1)) run <= 1'b1;
      else por_tmr <= por_tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovp_rec <= 1'b0;
      ovp_tmr <= '0;
    end else if (!pwr_ok) begin
      ovp_rec <= 1'b0;
      ovp_tmr <= '0;
    end else if (in_ovp) begin
      ovp_rec <= 1'b1;
      ovp_tmr <= '0;
    end else if (ovp_rec && tick) begin
      if (ovp_tmr == TW'(OVP_REC_TICKS - 1)) begin
        ovp_rec <= 1'b0;
        ovp_tmr <= '0;
      end else begin
        ovp_tmr <= ovp_tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_trip <= 1'b0;
      oc_blk  <= '0;
      oc_tmr  <= '0;
    end else if (!pwr_ok || !monitor) begin
      oc_trip <= 1'b0;
      oc_blk  <= '0;
      oc_tmr  <= '0;
    end else if (oc_trip) begin
      oc_blk <= '0;
      if (tick) begin
        if (oc_tmr == TW'(OC_REC_TICKS - 1)) begin
          oc_trip <= 1'b0;
          oc_tmr  <= '0;
        end else begin
          oc_tmr <= oc_tmr + 1'b1;
        end
      end
    end else if (oc_flag) begin
      if (oc_fire) begin
        oc_trip <= 1'b1;
        oc_blk  <= '0;
        oc_tmr  <= '0;
      end else if (tick) begin
        oc_blk <= oc_blk + 1'b1;
      end
    end else begin
      oc_blk <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bat_trip <= 1'b0;
      bat_blk  <= '0;
    end else if (!pwr_ok || !monitor) begin
      bat_trip <= 1'b0;
      bat_blk  <= '0;
    end else if (bat_trip) begin
      bat_blk <= '0;
      if (!bat_ovp) bat_trip <= 1'b0;
    end else if (bat_ovp) begin
      if (bat_fire) begin
        bat_trip <= 1'b1;
        bat_blk  <= '0;
      end else if (tick) begin
        bat_blk <= bat_blk + 1'b1;
      end
    end else begin
      bat_blk <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else if (!pwr_ok || disable_in) fcnt <= '0;
    else if (!at_limit) begin
      if (fsum >= CW1'(FAULT_LIMIT)) fcnt <= CW'(FAULT_LIMIT);
      else fcnt <= fsum[CW-1:0];
    end
  end

  assign latched = pwr_ok & at_limit;
  assign sw_en   = pwr_ok & run & ~disable_in & ~in_ovp & ~ovp_rec & ~hot &
                   ~oc_trip & ~bat_trip & ~at_limit;
  assign fault_n = ~(pwr_ok & (in_ovp | ovp_rec | oc_trip | bat_trip | at_limit));
endmodule

// File: rtl/chg_guard_seq_chk.sv
module chg_guard_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic in_ovp,
  input logic hot,
  input logic disable_in,
  input logic sw_en,
  input logic fault_n,
  input logic latched
);
  // R2
  supply_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (!sw_en && fault_n && !latched));
  // R3
  ovp_instant_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && in_ovp) |-> (!sw_en && !fault_n));
  // R9
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disable_in |-> !sw_en);
  // R11
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> !sw_en);
  // R8
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !disable_in) |=> (latched || !pwr_ok || $past(disable_in)));
  // R8
  latch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> (!fault_n && !sw_en));
  // R10
  on_means_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> fault_n);
endmodule

bind chg_guard_seq chg_guard_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .in_ovp(in_ovp), .hot(hot),
  .disable_in(disable_in), .sw_en(sw_en), .fault_n(fault_n), .latched(latched)
);

// File: tb/test_chg_guard_seq.sv
`timescale 1ns/1ps
module test_chg_guard_seq;
  localparam int POR = 20, OVPR = 15, OCB = 6, OCR = 25, BATB = 5, LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, pwr_ok = 1'b0, in_ovp = 1'b0, oc_flag = 1'b0;
  logic bat_ovp = 1'b0, hot = 1'b0, disable_in = 1'b0;
  logic sw_en, fault_n, latched;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  chg_guard_seq #(.POR_TICKS(POR), .OVP_REC_TICKS(OVPR), .OC_BLANK_TICKS(OCB),
                  .OC_REC_TICKS(OCR), .BAT_BLANK_TICKS(BATB), .FAULT_LIMIT(LIM))
  i_chg_guard_seq (.clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
    .in_ovp(in_ovp), .oc_flag(oc_flag), .bat_ovp(bat_ovp), .hot(hot),
    .disable_in(disable_in), .sw_en(sw_en), .fault_n(fault_n), .latched(latched));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic bat_event();
    bat_ovp = 1'b1; step(BATB);
    bat_ovp = 1'b0; step(1);
  endtask

  task automatic t_reset();
    step(2); rst_n = 1'b1; step(2);
    check("R2", "sw_en unpowered", sw_en, 1'b0);
    check("R2", "fault_n unpowered", fault_n, 1'b1);
    check("R2", "latched unpowered", latched, 1'b0);
  endtask

  task automatic t_por();
    pwr_ok = 1'b1; step(5);
    tick = 1'b0; step(30);
    check("R12", "no progress without tick", sw_en, 1'b0);
    tick = 1'b1; step(POR - 5 - 1);
    check("R1", "off one tick before end", sw_en, 1'b0);
    step(1);
    check("R1", "on after start-up", sw_en, 1'b1);
    check("R1", "fault_n clean", fault_n, 1'b1);
  endtask

  task automatic t_ovp();
    in_ovp = 1'b1; settle();
    check("R3", "ovp instant off", sw_en, 1'b0);
    check("R3", "ovp fault_n", fault_n, 1'b0);
    step(3); in_ovp = 1'b0; step(OVPR - 1);
    check("R4", "still recovering", sw_en, 1'b0);
    check("R10", "fault during recovery", fault_n, 1'b0);
    step(1);
    check("R4", "on after recovery", sw_en, 1'b1);
    check("R4", "fault_n released", fault_n, 1'b1);
  endtask

  task automatic t_oc();
    oc_flag = 1'b1; step(OCB - 1);
    oc_flag = 1'b0; step(1);
    oc_flag = 1'b1; step(OCB - 1);
    check("R5", "short oc ignored", sw_en, 1'b1);
    step(1);
    check("R5", "oc trips", sw_en, 1'b0);
    check("R10", "oc fault_n", fault_n, 1'b0);
    step(OCR - 1);
    check("R6", "still in oc recovery", sw_en, 1'b0);
    step(1);
    check("R6", "on after oc recovery", sw_en, 1'b1);
    step(OCB - 1);
    check("R6", "fresh blanking", sw_en, 1'b1);
    step(1);
    check("R6", "re-trips", sw_en, 1'b0);
    oc_flag = 1'b0; step(OCR);
    check("R6", "on after second recovery", sw_en, 1'b1);
  endtask

  task automatic t_bat();
    bat_ovp = 1'b1; step(BATB - 1);
    check("R7", "bat blanking", sw_en, 1'b1);
    step(1);
    check("R7", "bat trips", sw_en, 1'b0);
    check("R10", "bat fault_n", fault_n, 1'b0);
    step(10); bat_ovp = 1'b0; settle();
    check("R7", "off until edge", sw_en, 1'b0);
    step(1);
    check("R7", "on after bat clears", sw_en, 1'b1);
  endtask

  task automatic t_hot();
    hot = 1'b1; settle();
    check("R11", "hot off", sw_en, 1'b0);
    check("R10", "hot no fault", fault_n, 1'b1);
    step(4); hot = 1'b0; settle();
    check("R11", "hot clears at once", sw_en, 1'b1);
  endtask

  task automatic t_latch();
    disable_in = 1'b1; settle();
    check("R9", "disable off", sw_en, 1'b0);
    step(1); disable_in = 1'b0; settle();
    check("R9", "re-enabled", sw_en, 1'b1);
    for (int i = 0; i < LIM - 1; i++) bat_event();
    check("R8", "not latched below limit", latched, 1'b0);
    check("R8", "on below limit", sw_en, 1'b1);
    bat_ovp = 1'b1; step(BATB);
    check("R8", "latched at limit", latched, 1'b1);
    bat_ovp = 1'b0; oc_flag = 1'b1; step(OCB + 5);
    oc_flag = 1'b0; step(3);
    check("R8", "stays latched", latched, 1'b1);
    check("R8", "stays off", sw_en, 1'b0);
    check("R8", "fault held", fault_n, 1'b0);
    disable_in = 1'b1; step(1); disable_in = 1'b0; settle();
    check("R9", "latch cleared", latched, 1'b0);
    check("R9", "switch back", sw_en, 1'b1);
  endtask

  task automatic t_power();
    for (int i = 0; i < LIM - 1; i++) bat_event();
    pwr_ok = 1'b0; settle();
    check("R2", "supply drop off", sw_en, 1'b0);
    check("R2", "supply drop fault_n", fault_n, 1'b1);
    step(2); pwr_ok = 1'b1; step(POR - 1);
    check("R2", "start-up restarts", sw_en, 1'b0);
    step(1);
    check("R2", "on after restart", sw_en, 1'b1);
    bat_event();
    check("R2", "counter was cleared", latched, 1'b0);
  endtask

  initial begin
    t_reset();
    t_por();
    t_ovp();
    t_oc();
    t_bat();
    t_hot();
    t_latch();
    t_power();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule